// File: doc/BRIEF.md
# Masked Priority Format Table

This block keeps four host-loaded format entries. Each entry has an enable flag, a 16-bit match value, a 16-bit mask and a 6-bit price byte offset. A parser presents a 16-bit payload discriminator together with a qualifier. In that same cycle the block reports whether any enabled entry matches the discriminator under its mask. It also returns the price offset of the matching entry with the lowest index.

The lookup is pure combinational logic, so the parser can resolve the payload format in the beat where the discriminator arrives. No search state and no extra pipeline stage are needed. The host loads one whole entry at a time through a strobed write port. Reset disables every entry.

Top module: `disc_format_table`

## Requirements
- R1: While reset is held and after its release, every entry is disabled, so `hit` stays 0 for any discriminator until an entry is written with `wr_valid`=1.
- R2: A write with `wr_en`=1 stores `wr_valid`, `wr_value`, `wr_mask` and `wr_offset` into entry `wr_idx` at the next rising clock edge. The lookup does not see the new contents before that edge.
- R3: An entry matches when `(disc & mask) == (value & mask)`. A mask bit of 1 makes that discriminator bit significant, and a mask bit of 0 makes it a don't-care. A mask of 0x0000 therefore matches every discriminator.
- R4: When `disc_ok` is 0, `hit` is 0 and `sel_offset` is 0, whatever the table holds.
- R5: An entry whose enable flag is 0 never matches, even when its value and mask would match.
- R6: When several entries match, `sel_offset` takes the offset of the lowest-index matching entry. Entry 0 has the highest priority.
- R7: When no entry matches, `hit` is 0 and `sel_offset` is 0.
- R8: `hit` and `sel_offset` follow `disc` and `disc_ok` within the same cycle, with zero clock cycles of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low; disables all entries |
| wr_en | input | 1 | Host write strobe |
| wr_idx | input | 2 | Entry index to write |
| wr_valid | input | 1 | Enable flag to store |
| wr_value | input | 16 | Match value to store |
| wr_mask | input | 16 | Mask to store (1 = bit compared) |
| wr_offset | input | 6 | Price byte offset to store |
| disc | input | 16 | Payload discriminator |
| disc_ok | input | 1 | Discriminator qualifier |
| hit | output | 1 | At least one enabled entry matches |
| sel_offset | output | 6 | Offset of the lowest-index match, 0 on no match |

## Verification
The lookup results are due in the same cycle as the discriminator. The bench therefore changes `disc` and `disc_ok` just after a rising edge and samples `hit` and `sel_offset` at the following falling edge, with no clock edge in between. A table write is due one edge later. The bench samples once in the write cycle, where the old contents must still apply, and again after the edge, where the new entry must be active. A behavioural model updates its own copy of the table on each rising edge, and the bench compares against it at every falling edge.

// File: rtl/disc_format_table.sv
module disc_format_table #(
  parameter int ENTRIES = 4,
  parameter int DW      = 16,
  parameter int OW      = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [$clog2(ENTRIES)-1:0] wr_idx,
  input  logic                       wr_valid,
  input  logic [DW-1:0]              wr_value,
  input  logic [DW-1:0]              wr_mask,
  input  logic [OW-1:0]              wr_offset,
  input  logic [DW-1:0]              disc,
  input  logic                       disc_ok,
  output logic                       hit,
  output logic [OW-1:0]              sel_offset
);
  localparam int IW = $clog2(ENTRIES);

  logic [ENTRIES-1:0] vld;
  logic [DW-1:0]      val_q [ENTRIES];
  logic [DW-1:0]      msk_q [ENTRIES];
  logic [OW-1:0]      ofs_q [ENTRIES];
  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld[g]   <= 1'b0;
        val_q[g] <= '0;
        msk_q[g] <= '0;
        ofs_q[g] <= '0;
      end else if (wr_en && wr_idx == IW'(g)) begin
        vld[g]   <= wr_valid;
        val_q[g] <= wr_value;
        msk_q[g] <= wr_mask;
        ofs_q[g] <= wr_offset;
      end
    end

    assign match[g] = disc_ok && vld[g] &&
                      ((disc & msk_q[g]) == (val_q[g] & msk_q[g]));
  end

  assign hit = |match;

  always_comb begin
    sel_offset = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (match[i]) sel_offset = ofs_q[i];
  end
endmodule

module disc_format_table_chk #(
  parameter int ENTRIES = 4,
  parameter int OW      = 6
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_en,
  input logic [$clog2(ENTRIES)-1:0] wr_idx,
  input logic                       wr_valid,
  input logic                       disc_ok,
  input logic                       hit,
  input logic [OW-1:0]              sel_offset,
  input logic [ENTRIES-1:0]         vld
);
  AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_n) |-> vld == '0); // R1
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> vld[$past(wr_idx)] == $past(wr_valid)); // R2
  AST_NO_QUAL_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n) !disc_ok |-> !hit && sel_offset == '0); // R4
  AST_HIT_NEEDS_ENABLED: assert property (@(posedge clk) disable iff (!rst_n) hit |-> vld != '0); // R5
  AST_MISS_ZERO_OFFSET: assert property (@(posedge clk) disable iff (!rst_n) !hit |-> sel_offset == '0); // R7
endmodule

bind disc_format_table disc_format_table_chk #(.ENTRIES(ENTRIES), .OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
  .disc_ok(disc_ok), .hit(hit), .sel_offset(sel_offset), .vld(vld)
);

// File: tb/test_disc_format_table.sv
module test_disc_format_table;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_idx = '0;
  logic wr_valid = 1'b0;
  logic [15:0] wr_value = '0, wr_mask = '0, disc = '0;
  logic [5:0] wr_offset = '0;
  logic disc_ok = 1'b0;
  logic hit;
  logic [5:0] sel_offset;

  int total = 0, bad = 0;

  bit          m_v [4];
  logic [15:0] m_val [4], m_msk [4];
  logic [5:0]  m_ofs [4];

  always #5 clk = ~clk;

  disc_format_table i_disc_format_table (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
    .wr_value(wr_value), .wr_mask(wr_mask), .wr_offset(wr_offset),
    .disc(disc), .disc_ok(disc_ok), .hit(hit), .sel_offset(sel_offset)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) m_v[i] = 0;
    end else if (wr_en) begin
      m_v[wr_idx]   = wr_valid;
      m_val[wr_idx] = wr_value;
      m_msk[wr_idx] = wr_mask;
      m_ofs[wr_idx] = wr_offset;
    end
  end

  function automatic logic [6:0] model();
    if (disc_ok)
      for (int i = 0; i < 4; i++)
        if (m_v[i] && ((disc & m_msk[i]) == (m_val[i] & m_msk[i])))
          return {1'b1, m_ofs[i]};
    return 7'd0;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      logic [6:0] e;
      e = model();
      total++;
      if ({hit, sel_offset} !== e) begin
        bad++;
        $display("FAIL R8 model compare: got hit=%0b ofs=%0d exp hit=%0b ofs=%0d",
                 hit, sel_offset, e[6], e[5:0]);
      end
    end
  end

  task automatic chk(string tag, logic eh, logic [5:0] eo);
    total++;
    if (hit !== eh || sel_offset !== eo) begin
      bad++;
      $display("FAIL %s: got hit=%0b ofs=%0d exp hit=%0b ofs=%0d", tag, hit, sel_offset, eh, eo);
    end
  endtask

  task automatic wr(int idx, bit v, logic [15:0] val, logic [15:0] msk, logic [5:0] ofs);
    @(posedge clk); #1;
    wr_en = 1; wr_idx = 2'(idx); wr_valid = v; wr_value = val; wr_mask = msk; wr_offset = ofs;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic look(logic [15:0] d, logic ok);
    @(posedge clk); #1;
    disc = d; disc_ok = ok;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog: got timeout exp finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    disc_ok = 1; disc = 16'h0000;
    #1; chk("R1 in reset", 0, 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    look(16'h0000, 1); chk("R1 after reset", 0, 0);
    look(16'hFFFF, 1); chk("R1 after reset", 0, 0);

    // R2: write visible only after the edge
    disc = 16'h1234; disc_ok = 1;
    @(posedge clk); #1;
    wr_en = 1; wr_idx = 2; wr_valid = 1; wr_value = 16'h1234; wr_mask = 16'hFFFF; wr_offset = 6'd46;
    @(negedge clk); chk("R2 before edge", 0, 0);
    @(posedge clk); #1 wr_en = 0;
    @(negedge clk); chk("R2 after edge", 1, 46);

    // R3 masked compare
    wr(1, 1, 16'hAB00, 16'hFF00, 6'd45);
    look(16'hAB77, 1); chk("R3 masked hit", 1, 45);
    look(16'hAC77, 1); chk("R3 masked miss", 0, 0);
    look(16'h1235, 1); chk("R3 one bit off", 0, 0);

    // R4 qualifier low
    look(16'hAB77, 0); chk("R4 qualifier low", 0, 0);

    // R5 disabled entry
    wr(3, 0, 16'h5555, 16'hFFFF, 6'd47);
    look(16'h5555, 1); chk("R5 disabled entry", 0, 0);

    // R6 priority: entry 0 matches all
    wr(0, 1, 16'h0000, 16'h0000, 6'd44);
    look(16'hAB77, 1); chk("R6 entry0 wins", 1, 44);
    look(16'h1234, 1); chk("R3 zero mask any", 1, 44);
    wr(0, 0, 16'h0000, 16'h0000, 6'd44);
    wr(2, 1, 16'hAB00, 16'hFFF0, 6'd46);
    look(16'hAB07, 1); chk("R6 entry1 over entry2", 1, 45);
    wr(1, 0, 16'hAB00, 16'hFF00, 6'd45);
    look(16'hAB07, 1); chk("R6 entry2 alone", 1, 46);

    // R7 miss
    look(16'h9999, 1); chk("R7 miss zero", 0, 0);

    // R8 same-cycle response
    @(posedge clk); #1 disc = 16'hAB0F;
    #2 chk("R8 same cycle hit", 1, 46);
    disc = 16'hAB1F;
    #1 chk("R8 same cycle miss", 0, 0);

    // R1 reset mid-run clears table
    wr(3, 1, 16'h0000, 16'h0000, 6'd47);
    look(16'h4242, 1); chk("R3 zero mask any", 1, 47);
    @(posedge clk); #1 rst_n = 0;
    #1 chk("R1 reset clears", 0, 0);
    @(posedge clk); #1 rst_n = 1;
    look(16'h4242, 1); chk("R1 after second reset", 0, 0);

    repeat (2) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule